// File: doc/BRIEF.md
# Four-Mode Significand Rounder

This block shortens a binary significand to a chosen number of fraction bits. It applies one of four rounding rules, and a two-bit field inside a 16-bit control word selects the rule. The input is a sign bit and a significand with one integer bit and `FRAC` fraction bits. Three extra bits sit below the significand. The first is the guard bit, the second is the round bit, and the lowest is a sticky bit that the source has already OR-reduced from everything beneath it. A separate input gives the number of fraction bits to keep.

The result keeps the same alignment as the input. Kept positions hold the rounded value and dropped positions read as zero. A carry flag reports that rounding up overflowed the integer bit, so the caller can renormalise by adjusting its exponent. An inexact flag reports that any dropped bit was nonzero. The two directed modes look at the sign, so one magnitude can round up for one sign and down for the other. All outputs are registered and appear one clock after an accepted input.

Top module: `rnd_unit`

## Requirements
- R1: The rounding rule is taken only from control-word bits 11:10. Every other control-word bit has no effect on any output. The control word 0x037F selects round-to-nearest-even.
- R2: Field value 00 is round to nearest. The result increments by one unit of the last kept place when the dropped part is more than half a unit. It also increments on an exact tie when the last kept bit is 1.
- R3: Field value 01 rounds toward negative infinity. A negative inexact value grows in magnitude by one unit, and a positive value is truncated.
- R4: Field value 10 rounds toward positive infinity. A positive inexact value grows in magnitude by one unit, and a negative value is truncated.
- R5: Field value 11 truncates toward zero, so the result never increments and the carry flag is never set.
- R6: `out_inexact` is 1 exactly when some dropped bit is nonzero, in every mode. The dropped bits are the significand bits below the kept width together with the guard, round and sticky bits.
- R7: `out_carry` is 1 exactly when the increment overflows the kept significand. In that case `out_sig` is all zeros; for example, 1.111 rounded up gives carry 1 and 0.000.
- R8: `in_keep` gives the count of kept fraction bits. Any value above `FRAC` is treated as `FRAC`. The `FRAC - keep` lowest positions of `out_sig` are always zero.
- R9: When `in_valid` is 1 at a rising edge, the outputs for that input and `out_valid` = 1 appear after that edge. When `in_valid` is 0 at the edge, `out_valid` is 0 after it.
- R10: A synchronous active-high reset clears `out_valid`, `out_sig`, `out_carry` and `out_inexact`.
- R11: With three fraction bits kept, +1.0111 gives 1.100 under modes 00 and 10 and 1.011 under modes 01 and 11. The value -1.0111 gives magnitude 1.100 under modes 00 and 01 and 1.011 under modes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is present this cycle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_sig | input | FRAC+1 | Significand: integer bit on top, then FRAC fraction bits |
| in_grs | input | 3 | Guard, round and sticky bits below the significand |
| in_keep | input | KEEPW | Count of fraction bits to keep |
| ctrl_word | input | 16 | Control word; bits 11:10 choose the rounding rule |
| out_valid | output | 1 | Registered result is valid |
| out_sig | output | FRAC+1 | Rounded significand, same alignment as in_sig |
| out_carry | output | 1 | Rounding overflowed the integer bit |
| out_inexact | output | 1 | A nonzero bit was discarded |

## Verification
There is one register stage between the inputs and every output. The rounded significand, the carry, the inexact flag and the valid flag are all due just after the first rising edge following the cycle that presents the vector. The bench changes inputs on the falling edge and captures the reference result at that moment. It compares the outputs at the next falling edge, half a period after the edge that loads them, and then drives the next vector in the same step. One vector is therefore checked per cycle, and no check depends on the order of events at the clock edge.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_NEG_INF = 2'b01,
    RM_POS_INF = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  localparam int RC_LSB = 10;

  function automatic rmode_e mode_of(input logic [15:0] cw);
    return rmode_e'(cw[RC_LSB+1:RC_LSB]);
  endfunction

endpackage

// File: rtl/rnd_split.sv
module rnd_split #(
  parameter int FRAC  = 10,
  parameter int KEEPW = 4
) (
  input  logic [FRAC:0]      sig,
  input  logic [2:0]         grs,
  input  logic [KEEPW-1:0]   keep,
  output logic [FRAC:0]      trunc_sig,
  output logic [FRAC:0]      low_mask,
  output logic [FRAC:0]      unit_val,
  output logic               lsb,
  output logic               guard,
  output logic               sticky
);
  localparam int W  = FRAC + 1;
  localparam int EW = FRAC + 4;
  localparam int SW = $clog2(EW) + 1;

  logic [EW-1:0] ext;
  logic [SW-1:0] sh;
  logic [EW-1:0] below_g;

  assign ext = {sig, grs};

  always_comb begin
    if (int'(keep) > FRAC) sh = '0;
    else                   sh = SW'(FRAC - int'(keep));
    low_mask  = (W'(1) << sh) - W'(1);
    unit_val  = W'(1) << sh;
    trunc_sig = sig & ~low_mask;
    lsb       = sig[sh];
    guard     = ext[sh + SW'(2)];
    below_g   = (EW'(1) << (sh + SW'(2))) - EW'(1);
    sticky    = |(ext & below_g);
  end

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  rmode_e mode,
  input  logic   sign,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  output logic   round_up,
  output logic   inexact
);
  always_comb begin
    inexact = guard | sticky;
    unique case (mode)
      RM_NEAREST: round_up = guard & (sticky | lsb);
      RM_NEG_INF: round_up = inexact & sign;
      RM_POS_INF: round_up = inexact & ~sign;
      default:    round_up = 1'b0;
    endcase
  end
endmodule

// File: rtl/rnd_add.sv
module rnd_add #(
  parameter int W = 11
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] unit_val,
  input  logic         round_up,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W:0] wide;
  assign wide  = {1'b0, base} + (round_up ? {1'b0, unit_val} : '0);
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int FRAC  = 10,
  parameter int KEEPW = $clog2(FRAC + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [FRAC:0]     in_sig,
  input  logic [2:0]        in_grs,
  input  logic [KEEPW-1:0]  in_keep,
  input  logic [15:0]       ctrl_word,
  output logic              out_valid,
  output logic [FRAC:0]     out_sig,
  output logic              out_carry,
  output logic              out_inexact
);
  localparam int W = FRAC + 1;

  rmode_e        mode;
  logic [W-1:0]  trunc_sig, low_mask, unit_val, sum;
  logic          lsb, guard, sticky, round_up, inexact, carry;

  assign mode = mode_of(ctrl_word);

  rnd_split #(.FRAC(FRAC), .KEEPW(KEEPW)) u_split (
    .sig(in_sig), .grs(in_grs), .keep(in_keep),
    .trunc_sig(trunc_sig), .low_mask(low_mask), .unit_val(unit_val),
    .lsb(lsb), .guard(guard), .sticky(sticky)
  );

  rnd_decide u_decide (
    .mode(mode), .sign(in_sign), .lsb(lsb), .guard(guard), .sticky(sticky),
    .round_up(round_up), .inexact(inexact)
  );

  rnd_add #(.W(W)) u_add (
    .base(trunc_sig), .unit_val(unit_val), .round_up(round_up),
    .sum(sum), .carry(carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_sig     <= '0;
      out_carry   <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sig     <= sum;
        out_carry   <= carry;
        out_inexact <= inexact;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
  AST_TRUNC_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (in_valid && mode == RM_ZERO) |=> !out_carry); // R5
  AST_EXACT_CLEAN: assert property (@(posedge clk) disable iff (rst) (in_valid && !guard && !sticky) |=> (!out_inexact && !out_carry)); // R6
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst) out_carry |-> (out_sig == '0)); // R7
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst) in_valid |=> ((out_sig & $past(low_mask)) == '0)); // R8

endmodule

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
  localparam int FRAC  = 4;
  localparam int KEEPW = 3;
  localparam int W     = FRAC + 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_sign;
  logic [FRAC:0]    in_sig;
  logic [2:0]       in_grs;
  logic [KEEPW-1:0] in_keep;
  logic [15:0]      ctrl_word;
  logic             out_valid;
  logic [FRAC:0]    out_sig;
  logic             out_carry;
  logic             out_inexact;

  int n_chk  = 0;
  int n_fail = 0;
  bit pend   = 0;
  bit done   = 0;
  logic [FRAC:0] e_sig;
  logic          e_carry, e_inex;
  string         e_tag;

  always #2.5 clk = ~clk;

  rnd_unit #(.FRAC(FRAC), .KEEPW(KEEPW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_sig(in_sig), .in_grs(in_grs), .in_keep(in_keep), .ctrl_word(ctrl_word),
    .out_valid(out_valid), .out_sig(out_sig), .out_carry(out_carry),
    .out_inexact(out_inexact)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input bit s, input int sig, input int grs, input int keep, input int md);
    int v, k, sh, unit, q, rem, half, up, res;
    v = (sig << 3) | grs;
    k = (keep > FRAC) ? FRAC : keep;
    sh = FRAC - k;
    unit = 1 << (sh + 3);
    q = v / unit;
    rem = v % unit;
    half = unit / 2;
    e_inex = (rem != 0);
    case (md)
      0: up = (rem > half || (rem == half && (q % 2) == 1)) ? 1 : 0;
      1: up = (rem != 0 && s) ? 1 : 0;
      2: up = (rem != 0 && !s) ? 1 : 0;
      default: up = 0;
    endcase
    res = (q + up) << sh;
    e_carry = (res >> W) != 0;
    e_sig = W'(res);
  endtask

  task automatic check_pending();
    if (pend) begin
      chk({e_tag, " out_valid R9"}, int'(out_valid), 1);
      chk({e_tag, " sig"}, int'(out_sig), int'(e_sig));
      chk({e_tag, " carry R7"}, int'(out_carry), int'(e_carry));
      chk({e_tag, " inexact R6"}, int'(out_inexact), int'(e_inex));
      pend = 0;
    end
  endtask

  task automatic drive(input bit s, input int sig, input int grs, input int keep,
                       input logic [15:0] cw, input string tag);
    check_pending();
    in_valid  = 1'b1;
    in_sign   = s;
    in_sig    = W'(sig);
    in_grs    = 3'(grs);
    in_keep   = KEEPW'(keep);
    ctrl_word = cw;
    model(s, sig, grs, keep, int'(cw[11:10]));
    e_tag = tag;
    pend = 1;
    @(negedge clk);
  endtask

  task automatic fixed(input bit s, input int md, input int sig, input int grs,
                       input int keep, input int exp_sig, input int exp_c, input string tag);
    logic [15:0] cw;
    cw = 16'h037F;
    cw[11:10] = 2'(md);
    drive(s, sig, grs, keep, cw, tag);
    check_pending();
    chk({tag, " literal"}, int'(out_sig), exp_sig);
    chk({tag, " literal carry R7"}, int'(out_carry), exp_c);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R9 actual=running expected=done");
    finish_up();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_sig = '0; in_grs = '0;
    in_keep = '0; ctrl_word = 16'h037F;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("reset out_valid R10", int'(out_valid), 0);
    chk("reset out_sig R10", int'(out_sig), 0);
    chk("reset out_carry R10", int'(out_carry), 0);
    chk("reset out_inexact R10", int'(out_inexact), 0);
    rst = 1'b0;
    @(negedge clk);

    // R11: +/-1.0111 with three fraction bits kept (sig 10111, grs 000)
    fixed(0, 0, 5'b10111, 0, 3, 5'b11000, 0, "R11 R2 +near");
    fixed(0, 1, 5'b10111, 0, 3, 5'b10110, 0, "R11 R3 +down");
    fixed(0, 2, 5'b10111, 0, 3, 5'b11000, 0, "R11 R4 +up");
    fixed(0, 3, 5'b10111, 0, 3, 5'b10110, 0, "R11 R5 +trunc");
    fixed(1, 0, 5'b10111, 0, 3, 5'b11000, 0, "R11 R2 -near");
    fixed(1, 1, 5'b10111, 0, 3, 5'b11000, 0, "R11 R3 -down");
    fixed(1, 2, 5'b10111, 0, 3, 5'b10110, 0, "R11 R4 -up");
    fixed(1, 3, 5'b10111, 0, 3, 5'b10110, 0, "R11 R5 -trunc");
    // R7: 1.111 plus half unit, tie on odd -> wraps with carry
    fixed(0, 0, 5'b11111, 0, 3, 5'b00000, 1, "R7 R2 tie-odd wrap");
    // R2: tie on even stays
    fixed(0, 0, 5'b10101, 0, 3, 5'b10100, 0, "R2 tie-even");
    // R1: default control word selects nearest
    drive(0, 5'b10111, 0, 3, 16'h037F, "R1 default cw");

    // R9: idle cycle
    check_pending();
    in_valid = 1'b0;
    @(negedge clk);
    chk("idle out_valid R9", int'(out_valid), 0);

    // Exhaustive sweep; keep 5..7 exercises clamping (R8); random other cw bits (R1)
    for (int keep = 0; keep < 8; keep++)
      for (int md = 0; md < 4; md++)
        for (int s = 0; s < 2; s++)
          for (int v = 0; v < 256; v++) begin
            logic [15:0] cw;
            string tg;
            cw = 16'($urandom);
            cw[11:10] = 2'(md);
            case (md)
              0: tg = "R1 R2 sweep";
              1: tg = "R1 R3 sweep";
              2: tg = "R1 R4 sweep";
              default: tg = "R1 R5 sweep";
            endcase
            if (keep > FRAC) tg = {tg, " R8"};
            drive(s[0], v >> 3, v & 7, keep, cw, tg);
          end
    check_pending();
    in_valid = 1'b0;
    @(negedge clk);
    finish_up();
  end

endmodule